// File: doc/BRIEF.md
# Preemptive Priority Bus Arbiter

This block is the central arbiter of a shared system bus. It picks one owner at a time from three kinds of requester. The memory refresh requester has the highest priority. The system processor's override request comes next. Sixteen numbered device levels come last, and among them the lowest number wins. Level 2 is conventionally wired to the floppy controller. Level 15 is the processor's own default level.

An owner keeps the bus until it drops its request or pulses the transfer-done input. The arbiter then spends exactly one idle cycle and arbitrates again on the next clock edge. Requests that arrive during a transfer, including refresh and processor override, never cut that transfer short. They wait for the transfer boundary. Once the processor holds the bus, every pending device request is deferred until the processor lets go. With no requester the bus parks on the processor's default level 15, and the grant-valid strobe stays low.

Top module: `busarb_top`

## Requirements
- R1: After reset, and in every cycle without an active grant, `grant_valid` is 0, `grant_kind` is 0 (none) and `grant_level` reads the park level 15.
- R2: When no grant is active and at least one request is present, a grant becomes active (`grant_valid`=1) after the next rising clock edge. With no request present, the arbiter stays idle.
- R3: Among device requests alone, the lowest-numbered requesting level wins. `grant_kind` reads 3 (device) and `grant_level` gives that level number.
- R4: A refresh request wins over every other simultaneous request. Its grant shows `grant_kind`=1 with `grant_level` reading 15.
- R5: A processor override request wins over all device requests and loses to refresh. Its grant shows `grant_kind`=2 with `grant_level` reading 15.
- R6: While the owner's request stays high and `xfer_done` stays low, `grant_valid`, `grant_kind` and `grant_level` do not change, whatever other requests do.
- R7: A grant ends on the edge where the owner's request is low or `xfer_done` is high. The following cycle has `grant_valid`=0 before any new grant appears, even for the same requester.
- R8: A processor override raised during a device transfer does not take the bus until that transfer ends. It then wins the next arbitration if no refresh request is present.
- R9: While the processor holds the bus, pending device requests are not granted. They are served after the processor releases the bus.
- R10: `xfer_done` asserted while no grant is active has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| refresh_req | input | 1 | Memory refresh request (highest priority) |
| cpu_req | input | 1 | Processor override request |
| dev_req | input | 16 | Device requests, bit n is level n |
| xfer_done | input | 1 | Current owner signals end of transfer |
| grant_valid | output | 1 | A grant is active |
| grant_kind | output | 2 | 0 none, 1 refresh, 2 processor, 3 device |
| grant_level | output | 4 | Granted device level, or 15 otherwise |

## Verification
Each device level is first requested alone. This shows that the encoded level matches the requesting bit and that release always inserts the idle gap. Every unordered pair of device levels is then requested together, and the lower member is dropped. This separates lowest-number-wins from any other ordering, and it shows that the loser is still served afterwards. All eight combinations of refresh, processor and a multi-bit device pattern pin down the ordering of the three classes. Directed sequences raise refresh and processor requests in the middle of transfers, and they pulse `xfer_done` with the request still high or with the arbiter idle. These sequences separate waiting for the transfer boundary from preemption, and a real release from a spurious one.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    GK_NONE    = 2'd0,
    GK_REFRESH = 2'd1,
    GK_CPU     = 2'd2,
    GK_DEV     = 2'd3
  } grant_kind_e;

endpackage

// File: rtl/busarb_resolver.sv
module busarb_resolver
  import busarb_pkg::*;
#(
  parameter int NUM_DEV = 16,
  localparam int LVL_W  = $clog2(NUM_DEV)
) (
  input  logic               refresh_req,
  input  logic               cpu_req,
  input  logic [NUM_DEV-1:0] dev_req,
  output grant_kind_e        win_kind,
  output logic [LVL_W-1:0]   win_level,
  output logic               any_req
);

  localparam logic [LVL_W-1:0] PARK_LEVEL = LVL_W'(NUM_DEV - 1);

  logic [NUM_DEV:0]   seen_below;
  logic [NUM_DEV-1:0] first_hot;
  logic               any_dev;

  assign seen_below[0] = 1'b0;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_chain
    assign first_hot[g]      = dev_req[g] & ~seen_below[g];
    assign seen_below[g + 1] = seen_below[g] | dev_req[g];
  end

  assign any_dev = seen_below[NUM_DEV];

  function automatic logic [LVL_W-1:0] onehot_index(input logic [NUM_DEV-1:0] oh);
    logic [LVL_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (oh[i]) idx = idx | LVL_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    win_kind  = GK_NONE;
    win_level = PARK_LEVEL;
    if (refresh_req) begin
      win_kind = GK_REFRESH;
    end else if (cpu_req) begin
      win_kind = GK_CPU;
    end else if (any_dev) begin
      win_kind  = GK_DEV;
      win_level = onehot_index(first_hot);
    end
  end

  assign any_req = refresh_req | cpu_req | any_dev;

endmodule

// File: rtl/busarb_release.sv
module busarb_release
  import busarb_pkg::*;
#(
  parameter int NUM_DEV = 16,
  localparam int LVL_W  = $clog2(NUM_DEV)
) (
  input  logic               grant_valid,
  input  grant_kind_e        grant_kind,
  input  logic [LVL_W-1:0]   grant_level,
  input  logic               refresh_req,
  input  logic               cpu_req,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               xfer_done,
  output logic               owner_req,
  output logic               release_evt
);

  always_comb begin
    unique case (grant_kind)
      GK_REFRESH: owner_req = refresh_req;
      GK_CPU:     owner_req = cpu_req;
      GK_DEV:     owner_req = dev_req[grant_level];
      default:    owner_req = 1'b0;
    endcase
  end

  assign release_evt = grant_valid & (xfer_done | ~owner_req);

endmodule

// File: rtl/busarb_grant_reg.sv
module busarb_grant_reg
  import busarb_pkg::*;
#(
  parameter int NUM_DEV = 16,
  localparam int LVL_W  = $clog2(NUM_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_evt,
  input  logic             release_evt,
  input  grant_kind_e      win_kind,
  input  logic [LVL_W-1:0] win_level,
  output logic             grant_valid,
  output grant_kind_e      grant_kind,
  output logic [LVL_W-1:0] grant_level
);

  localparam logic [LVL_W-1:0] PARK_LEVEL = LVL_W'(NUM_DEV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_kind  <= GK_NONE;
      grant_level <= PARK_LEVEL;
    end else if (arb_evt) begin
      grant_valid <= 1'b1;
      grant_kind  <= win_kind;
      grant_level <= win_level;
    end else if (release_evt) begin
      grant_valid <= 1'b0;
      grant_kind  <= GK_NONE;
      grant_level <= PARK_LEVEL;
    end
  end

endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
#(
  parameter int NUM_DEV = 16,
  localparam int LVL_W  = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               refresh_req,
  input  logic               cpu_req,
  input  logic [NUM_DEV-1:0] dev_req,
  input  logic               xfer_done,
  output logic               grant_valid,
  output logic [1:0]         grant_kind,
  output logic [LVL_W-1:0]   grant_level
);

  grant_kind_e      win_kind;
  logic [LVL_W-1:0] win_level;
  logic             any_req;
  grant_kind_e      cur_kind;
  logic             owner_req;
  logic             release_evt;
  logic             arb_evt;
  logic             defer_evt;

  busarb_resolver #(.NUM_DEV(NUM_DEV)) resolver_i (
    .refresh_req (refresh_req),
    .cpu_req     (cpu_req),
    .dev_req     (dev_req),
    .win_kind    (win_kind),
    .win_level   (win_level),
    .any_req     (any_req)
  );

  busarb_release #(.NUM_DEV(NUM_DEV)) release_i (
    .grant_valid (grant_valid),
    .grant_kind  (cur_kind),
    .grant_level (grant_level),
    .refresh_req (refresh_req),
    .cpu_req     (cpu_req),
    .dev_req     (dev_req),
    .xfer_done   (xfer_done),
    .owner_req   (owner_req),
    .release_evt (release_evt)
  );

  assign arb_evt   = ~grant_valid & any_req;
  assign defer_evt = grant_valid & (cur_kind == GK_CPU) & (|dev_req);

  busarb_grant_reg #(.NUM_DEV(NUM_DEV)) grant_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .arb_evt     (arb_evt),
    .release_evt (release_evt),
    .win_kind    (win_kind),
    .win_level   (win_level),
    .grant_valid (grant_valid),
    .grant_kind  (cur_kind),
    .grant_level (grant_level)
  );

  assign grant_kind = cur_kind;

endmodule

// File: rtl/busarb_checker.sv
module busarb_checker #(
  parameter int NUM_DEV = 16,
  localparam int LVL_W  = $clog2(NUM_DEV)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               refresh_req,
  input logic               cpu_req,
  input logic [NUM_DEV-1:0] dev_req,
  input logic               grant_valid,
  input logic [1:0]         grant_kind,
  input logic [LVL_W-1:0]   grant_level,
  input logic               release_evt,
  input logic               defer_evt
);

  localparam logic [LVL_W-1:0] PARK_LEVEL = LVL_W'(NUM_DEV - 1);

  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_kind == 2'd0 && grant_level == PARK_LEVEL)); // R1

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && !refresh_req && !cpu_req && dev_req == '0) |=> !grant_valid); // R2

  AST_IDLE_TO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && (refresh_req || cpu_req || dev_req != '0)) |=> grant_valid); // R2

  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && refresh_req) |=> (grant_kind == 2'd1)); // R4

  AST_CPU_OVER_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && cpu_req && !refresh_req) |=> (grant_kind == 2'd2)); // R5

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !release_evt) |=>
      (grant_valid && $stable(grant_kind) && $stable(grant_level))); // R6

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !grant_valid); // R7

  AST_CPU_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_evt && !release_evt) |=> (grant_kind == 2'd2)); // R9

endmodule

bind busarb_top busarb_checker #(.NUM_DEV(NUM_DEV)) checker_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_req (refresh_req),
  .cpu_req     (cpu_req),
  .dev_req     (dev_req),
  .grant_valid (grant_valid),
  .grant_kind  (grant_kind),
  .grant_level (grant_level),
  .release_evt (release_evt),
  .defer_evt   (defer_evt)
);

// File: tb/busarb_top_tb_top.sv
`timescale 1ns/1ps
module busarb_top_tb_top;

  localparam int NDEV = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            refresh_req = 1'b0;
  logic            cpu_req = 1'b0;
  logic [NDEV-1:0] dev_req = '0;
  logic            xfer_done = 1'b0;
  logic            grant_valid;
  logic [1:0]      grant_kind;
  logic [3:0]      grant_level;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  busarb_top #(.NUM_DEV(NDEV)) dut_i (
    .clk, .rst_n, .refresh_req, .cpu_req, .dev_req, .xfer_done,
    .grant_valid, .grant_kind, .grant_level
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic ev, input logic [1:0] ek, input logic [3:0] el);
    checks++;
    if (grant_valid !== ev || grant_kind !== ek || grant_level !== el) begin
      failures++;
      $display("FAIL %s: got valid=%0b kind=%0d level=%0d, expected valid=%0b kind=%0d level=%0d",
               tag, grant_valid, grant_kind, grant_level, ev, ek, el);
    end
  endtask

  // Expected winner from an idle state, derived from the priority rules
  task automatic expect_win(input logic r, input logic c, input logic [NDEV-1:0] d,
                            output logic ev, output logic [1:0] ek, output logic [3:0] el);
    ev = 1'b1; ek = 2'd0; el = 4'd15;
    if (r) ek = 2'd1;
    else if (c) ek = 2'd2;
    else if (d != '0) begin
      ek = 2'd3;
      for (int i = NDEV - 1; i >= 0; i--) if (d[i]) el = 4'(i);
    end else ev = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ev;
    logic [1:0] ek;
    logic [3:0] el;

    repeat (3) tick();
    chk("R1 reset park", 1'b0, 2'd0, 4'd15);
    rst_n = 1'b1;
    tick();
    chk("R1 idle after reset", 1'b0, 2'd0, 4'd15);

    // R10: done while idle
    xfer_done = 1'b1;
    tick();
    chk("R10 done while idle", 1'b0, 2'd0, 4'd15);
    xfer_done = 1'b0;

    // R2/R3 single-level sweep
    for (int i = 0; i < NDEV; i++) begin
      dev_req = NDEV'(1) << i;
      tick();
      chk("R2 R3 single level grant", 1'b1, 2'd3, 4'(i));
      tick();
      chk("R6 single level held", 1'b1, 2'd3, 4'(i));
      dev_req = '0;
      tick();
      chk("R7 single level release", 1'b0, 2'd0, 4'd15);
    end

    // R3/R7 all pairs
    for (int i = 0; i < NDEV; i++) begin
      for (int j = i + 1; j < NDEV; j++) begin
        dev_req = (NDEV'(1) << i) | (NDEV'(1) << j);
        tick();
        chk("R3 pair lower wins", 1'b1, 2'd3, 4'(i));
        dev_req = NDEV'(1) << j;
        tick();
        chk("R7 pair idle gap", 1'b0, 2'd0, 4'd15);
        tick();
        chk("R3 pair loser served", 1'b1, 2'd3, 4'(j));
        dev_req = '0;
        tick();
      end
    end

    // R4/R5 class ordering
    for (int m = 0; m < 8; m++) begin
      refresh_req = m[2];
      cpu_req     = m[1];
      dev_req     = m[0] ? 16'h0A40 : '0;
      expect_win(refresh_req, cpu_req, dev_req, ev, ek, el);
      tick();
      chk("R4 R5 class ordering", ev, ek, el);
      refresh_req = 1'b0; cpu_req = 1'b0; dev_req = '0;
      tick();
      chk("R7 class ordering release", 1'b0, 2'd0, 4'd15);
    end

    // R8/R6: processor waits for device transfer, R9 defers devices
    dev_req = 16'h0020;
    tick();
    chk("R3 device 5 granted", 1'b1, 2'd3, 4'd5);
    cpu_req = 1'b1;
    dev_req = 16'h0021;
    tick();
    chk("R8 processor waits", 1'b1, 2'd3, 4'd5);
    tick();
    chk("R6 device still held", 1'b1, 2'd3, 4'd5);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R7 done releases", 1'b0, 2'd0, 4'd15);
    tick();
    chk("R8 processor after boundary", 1'b1, 2'd2, 4'd15);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R9 devices deferred", 1'b1, 2'd2, 4'd15);
    end
    cpu_req = 1'b0;
    tick();
    chk("R7 processor release gap", 1'b0, 2'd0, 4'd15);
    tick();
    chk("R9 deferred device served", 1'b1, 2'd3, 4'd0);

    // R4/R6: refresh and processor arrive mid-transfer, refresh wins at boundary
    refresh_req = 1'b1;
    cpu_req = 1'b1;
    tick();
    chk("R6 refresh waits", 1'b1, 2'd3, 4'd0);
    dev_req = 16'h0020;
    tick();
    chk("R7 owner drop releases", 1'b0, 2'd0, 4'd15);
    tick();
    chk("R4 refresh at boundary", 1'b1, 2'd1, 4'd15);
    refresh_req = 1'b0;
    tick();
    chk("R7 refresh release", 1'b0, 2'd0, 4'd15);
    tick();
    chk("R5 processor after refresh", 1'b1, 2'd2, 4'd15);
    cpu_req = 1'b0;
    tick();
    tick();
    chk("R3 device after processor", 1'b1, 2'd3, 4'd5);

    // R7: done with request still high gives an idle cycle then re-grant
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    chk("R7 done with request high", 1'b0, 2'd0, 4'd15);
    tick();
    chk("R7 same device re-granted", 1'b1, 2'd3, 4'd5);
    dev_req = '0;
    tick();
    tick();
    chk("R1 parked at end", 1'b0, 2'd0, 4'd15);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule